// File: doc/BRIEF.md
# Recirculating Serial Byte Loop Memory

This block stores a fixed number of bytes in one long shift register that forms a closed loop. Data moves one bit position per accepted shift step, always toward a single output end, and the bit sitting at that end is visible on a serial output pin. Nothing else in the storage can be read or written directly. A mode pin selects what enters the far end of the chain on each step. In one setting the output bit is fed back in, so the contents circulate without loss. In the other setting the external serial input is taken in instead, and the bit leaving the output end is dropped.

Two small counters follow the loop as it turns. A bit counter tells which bit of the current byte is at the output end. A byte counter names the byte that is currently being presented there. A controller uses these counters to wait for a chosen byte to arrive. It then switches to write mode for exactly eight steps that begin on a byte boundary, and switches back to recirculation. Bytes leave the loop least significant bit first, and in that same order they are written. There is no stream handshake. The shift strobe is the only pacing signal, and the block never stalls it.

Top module: `serial_byte_loop`

## Requirements
- R1: Reset clears every storage bit, the bit counter and the byte counter. After reset the serial output is 0, `bit_pos` is 0, `byte_addr` is 0, and `byte_edge` is 1.
- R2: On a clock where `shift_en` is low, the storage, `bit_pos` and `byte_addr` keep their values, whatever `recirc` and `sin_bit` do. As a result, `sout_bit` stays unchanged.
- R3: On an accepted shift with `recirc` = 0, `sin_bit` enters the input end of the loop. A bit written this way appears on `sout_bit` exactly 256 accepted shifts later.
- R4: On an accepted shift with `recirc` = 1, the bit on `sout_bit` is fed back into the input end and `sin_bit` is ignored. After 256 such shifts, the output again presents the same bit sequence as before.
- R5: `bit_pos` advances by one on each accepted shift and wraps from 7 to 0.
- R6: `byte_addr` advances by one only on the accepted shift that moves `bit_pos` from 7 to 0. It wraps from 31 to 0.
- R7: `byte_edge` is high exactly when `bit_pos` is 0.
- R8: Bytes are presented least significant bit first. When `byte_addr` = k and `bit_pos` = j, `sout_bit` carries bit j of byte k. The bytes written in a full write pass that starts at address 0 are stored as bytes 0 to 31, in that order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_en | input | 1 | Accept one shift step on this clock |
| recirc | input | 1 | 1 = feed output back into the loop, 0 = take `sin_bit` |
| sin_bit | input | 1 | External serial data for write mode |
| sout_bit | output | 1 | Bit currently at the output end of the loop |
| bit_pos | output | 3 | Index of that bit within its byte |
| byte_addr | output | 5 | Index of the byte at the output end |
| byte_edge | output | 1 | High when `bit_pos` is 0 |

## Verification
There are two points where separate functions act on the same accepted shift. The first is the step that completes a byte write: there the bit counter wraps, the byte counter advances, and the mode changes from write back to recirculation. The second is writing byte 31, where the byte counter's 31-to-0 wrap falls on the very step that stores the final written bit. The bench provokes both cases in one pass that overwrites bytes 5 and 31 inside a recirculating loop. Its scoreboard then expects the next full pass to return the original pattern, with only those two bytes replaced, while the counters are checked on every step of the wrap.

// File: rtl/loop_pkg.sv
package loop_pkg;

  // Source of the bit entering the input end of the loop.
  typedef enum logic {
    FEED_EXTERNAL = 1'b0,
    FEED_LOOPBACK = 1'b1
  } feed_sel_e;

endpackage

// File: rtl/loop_feed_mux.sv
module loop_feed_mux
  import loop_pkg::*;
(
  input  logic recirc,
  input  logic sin_bit,
  input  logic tail_bit,
  output logic feed_bit
);

  feed_sel_e sel;

  always_comb begin
    sel = (recirc) ? FEED_LOOPBACK : FEED_EXTERNAL;
    unique case (sel)
      FEED_LOOPBACK: feed_bit = tail_bit;
      default:       feed_bit = sin_bit;
    endcase
  end

endmodule

// File: rtl/loop_shift_chain.sv
module loop_shift_chain #(
  parameter int BYTES     = 32,
  parameter int BYTE_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic feed_bit,
  output logic tail_bit
);

  localparam int TOTAL = BYTES * BYTE_BITS;

  // Each lane is one byte slot; lane 0 is at the output end.
  logic [BYTE_BITS-1:0] lane   [BYTES];
  logic                 lane_in[BYTES];

  genvar g;
  generate
    for (g = 0; g < BYTES; g++) begin : g_lane
      if (g == BYTES - 1) begin : g_head
        assign lane_in[g] = feed_bit;
      end else begin : g_body
        assign lane_in[g] = lane[g+1][0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lane[g] <= '0;
        end else if (step) begin
          lane[g] <= {lane_in[g], lane[g][BYTE_BITS-1:1]};
        end
      end
    end
  endgenerate

  assign tail_bit = lane[0][0];

  initial begin
    if (TOTAL < 2) $error("loop_shift_chain: TOTAL too small");
  end

endmodule

// File: rtl/loop_position.sv
module loop_position #(
  parameter int BYTES     = 32,
  parameter int BYTE_BITS = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         step,
  output logic [$clog2(BYTE_BITS)-1:0] bit_pos,
  output logic [$clog2(BYTES)-1:0]     byte_addr,
  output logic                         byte_edge
);

  localparam int BW = $clog2(BYTE_BITS);
  localparam int AW = $clog2(BYTES);
  localparam logic [BW-1:0] BIT_LAST  = BW'(BYTE_BITS - 1);
  localparam logic [AW-1:0] ADDR_LAST = AW'(BYTES - 1);

  logic [BW-1:0] bit_q;
  logic [AW-1:0] addr_q;
  logic          last_bit;

  assign last_bit = (bit_q == BIT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
    end else if (step) begin
      bit_q <= last_bit ? '0 : bit_q + BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (step && last_bit) begin
      addr_q <= (addr_q == ADDR_LAST) ? '0 : addr_q + AW'(1);
    end
  end

  assign bit_pos   = bit_q;
  assign byte_addr = addr_q;
  assign byte_edge = (bit_q == '0);

endmodule

// File: rtl/serial_byte_loop.sv
module serial_byte_loop #(
  parameter int BYTES     = 32,
  parameter int BYTE_BITS = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         shift_en,
  input  logic                         recirc,
  input  logic                         sin_bit,
  output logic                         sout_bit,
  output logic [$clog2(BYTE_BITS)-1:0] bit_pos,
  output logic [$clog2(BYTES)-1:0]     byte_addr,
  output logic                         byte_edge
);

  logic tail_bit;
  logic feed_bit;

  loop_feed_mux u_mux (
    .recirc   (recirc),
    .sin_bit  (sin_bit),
    .tail_bit (tail_bit),
    .feed_bit (feed_bit)
  );

  loop_shift_chain #(
    .BYTES     (BYTES),
    .BYTE_BITS (BYTE_BITS)
  ) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (shift_en),
    .feed_bit (feed_bit),
    .tail_bit (tail_bit)
  );

  loop_position #(
    .BYTES     (BYTES),
    .BYTE_BITS (BYTE_BITS)
  ) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (shift_en),
    .bit_pos   (bit_pos),
    .byte_addr (byte_addr),
    .byte_edge (byte_edge)
  );

  assign sout_bit = tail_bit;

endmodule

// File: rtl/serial_byte_loop_chk.sv
module serial_byte_loop_chk #(
  parameter int BYTES     = 32,
  parameter int BYTE_BITS = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         shift_en,
  input logic                         sout_bit,
  input logic [$clog2(BYTE_BITS)-1:0] bit_pos,
  input logic [$clog2(BYTES)-1:0]     byte_addr,
  input logic                         byte_edge
);

  localparam int BW = $clog2(BYTE_BITS);
  localparam int AW = $clog2(BYTES);
  localparam logic [BW-1:0] BIT_LAST  = BW'(BYTE_BITS - 1);
  localparam logic [AW-1:0] ADDR_LAST = AW'(BYTES - 1);

  a_r2_hold_counters: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> ($stable(bit_pos) && $stable(byte_addr)));

  a_r2_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sout_bit));

  a_r5_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && bit_pos != BIT_LAST) |=> bit_pos == $past(bit_pos) + BW'(1));

  a_r5_bit_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && bit_pos == BIT_LAST) |=> bit_pos == '0);

  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && bit_pos == BIT_LAST && byte_addr != ADDR_LAST)
      |=> byte_addr == $past(byte_addr) + AW'(1));

  a_r6_addr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && bit_pos == BIT_LAST && byte_addr == ADDR_LAST) |=> byte_addr == '0);

  a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && bit_pos != BIT_LAST) |=> $stable(byte_addr));

  a_r7_edge_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && bit_pos == BIT_LAST) |=> byte_edge);

  a_r7_edge_off: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && bit_pos != BIT_LAST) |=> !byte_edge);

endmodule

bind serial_byte_loop serial_byte_loop_chk #(
  .BYTES     (BYTES),
  .BYTE_BITS (BYTE_BITS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .shift_en  (shift_en),
  .sout_bit  (sout_bit),
  .bit_pos   (bit_pos),
  .byte_addr (byte_addr),
  .byte_edge (byte_edge)
);

// File: tb/serial_byte_loop_tb.sv
module serial_byte_loop_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       shift_en = 1'b0;
  logic       recirc = 1'b1;
  logic       sin_bit = 1'b0;
  logic       sout_bit;
  logic [2:0] bit_pos;
  logic [4:0] byte_addr;
  logic       byte_edge;

  int n_checks = 0;
  int n_errors = 0;

  logic [7:0] exp_q[$];
  string      exp_req = "R1";
  bit         mon_on = 1'b0;
  int         bexp = 0;
  int         aexp = 0;
  logic [7:0] got_byte = '0;

  always #2 clk = ~clk;

  serial_byte_loop u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .recirc    (recirc),
    .sin_bit   (sin_bit),
    .sout_bit  (sout_bit),
    .bit_pos   (bit_pos),
    .byte_addr (byte_addr),
    .byte_edge (byte_edge)
  );

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 5) & 255);
  endfunction

  task automatic check(input string req, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: samples at the falling edge the bit that the next rising edge consumes.
  always @(negedge clk) begin
    if (mon_on && shift_en) begin
      check("R5 bit_pos", int'(bit_pos), bexp);
      check("R6 byte_addr", int'(byte_addr), aexp);
      check("R7 byte_edge", int'(byte_edge), (bexp == 0) ? 1 : 0);
      got_byte[bexp] = sout_bit;
      if (bexp == 7) begin
        if (exp_q.size() == 0) begin
          check({exp_req, " scoreboard underflow"}, 1, 0);
        end else begin
          check({exp_req, " R8 byte"}, int'(got_byte), int'(exp_q.pop_front()));
        end
        bexp = 0;
        aexp = (aexp + 1) % 32;
      end else begin
        bexp = bexp + 1;
      end
    end
  end

  task automatic shift1(input logic rc, input logic b);
    @(posedge clk);
    #1;
    shift_en = 1'b1;
    recirc   = rc;
    sin_bit  = b;
  endtask

  task automatic go_idle();
    @(posedge clk);
    #1;
    shift_en = 1'b0;
  endtask

  // Full write pass: bytes in wr[] enter the loop LSB first.
  task automatic write_pass(input logic [7:0] wr[32]);
    for (int k = 0; k < 32; k++)
      for (int j = 0; j < 8; j++)
        shift1(1'b0, wr[k][j]);
    go_idle();
  endtask

  // Recirculating pass with sin_bit driven to a value that must be ignored.
  task automatic recirc_pass(input logic junk);
    for (int i = 0; i < 256; i++) shift1(1'b1, junk ^ i[0]);
    go_idle();
  endtask

  logic [7:0] base[32];
  logic [7:0] mod_img[32];

  initial begin
    for (int k = 0; k < 32; k++) begin
      base[k]    = pat(k);
      mod_img[k] = pat(k);
    end
    mod_img[5]  = 8'hA5;
    mod_img[31] = 8'h3C;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 sout", int'(sout_bit), 0);
    check("R1 bit_pos", int'(bit_pos), 0);
    check("R1 byte_addr", int'(byte_addr), 0);
    check("R7 edge after reset", int'(byte_edge), 1);
    mon_on = 1'b1;

    // R1 and R3: old contents read back as zeros while the pattern is written.
    exp_req = "R1/R3";
    for (int k = 0; k < 32; k++) exp_q.push_back(8'h00);
    write_pass(base);

    // R4: recirculation returns the written pattern; sin_bit ignored.
    exp_req = "R3/R4";
    for (int k = 0; k < 32; k++) exp_q.push_back(base[k]);
    recirc_pass(1'b1);

    // R2: no shift while shift_en is low.
    begin
      logic s0;
      logic [2:0] b0;
      logic [4:0] a0;
      @(negedge clk);
      s0 = sout_bit; b0 = bit_pos; a0 = byte_addr;
      check("R8 byte0 bit0", int'(s0), int'(base[0][0]));
      for (int i = 0; i < 10; i++) begin
        @(posedge clk);
        #1 recirc = i[0]; sin_bit = ~s0;
      end
      @(negedge clk);
      check("R2 sout held", int'(sout_bit), int'(s0));
      check("R2 bit_pos held", int'(bit_pos), int'(b0));
      check("R2 byte_addr held", int'(byte_addr), int'(a0));
    end

    // R3/R6: overwrite bytes 5 and 31 in place; byte 31 write meets the address wrap.
    exp_req = "R4";
    for (int k = 0; k < 32; k++) exp_q.push_back(base[k]);
    for (int k = 0; k < 32; k++)
      for (int j = 0; j < 8; j++)
        if (k == 5 || k == 31) shift1(1'b0, mod_img[k][j]);
        else                   shift1(1'b1, 1'b0);
    go_idle();

    exp_req = "R3 partial";
    for (int k = 0; k < 32; k++) exp_q.push_back(mod_img[k]);
    recirc_pass(1'b0);

    @(negedge clk);
    check("R6 addr after passes", int'(byte_addr), 0);
    check("R4 queue drained", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule